// File: doc/BRIEF.md
# Serial Receive FIFO with Programmable Flow-Control Levels

This block is the receive-side byte queue of a serial port. A deserializer pushes each byte it assembles with a one-cycle write strobe. The host takes bytes out, oldest first, with a one-cycle read strobe. The queue holds sixteen bytes and reports how many it currently holds.

Two independent fill levels are set through a 16-bit control word. Each level is picked from a fixed, non-linear table of encodings.

- The first level raises a "data ready" status flag once the fill reaches or passes it.
- The second level drives the request-to-send (RTS) flow-control pin high once the fill goes strictly past it. This pin is how the block tells the far end to pause.

The control word also carries a queue-flush bit and a loopback enable. The loopback enable is handed to the serial datapath. The control word can be read and written at any time. A push arriving while the queue is full is discarded and sets a sticky overrun indication.

Top module: `rxq_fifo_top`

## Requirements
- R1: After synchronous reset the fill count is 0, the control word reads 16'h0000, and `rts_out`, `rx_full_flag`, `overrun` and `loopback_en` are all low.
- R2: Control field positions are: RTS level select in bits 10:8, data-ready level select in bits 7:6, queue flush in bit 1, loopback in bit 0. These fields read back as written, and every other bit (15:11 and 5:2) always reads 0. A write of 16'hFFFF reads back as 16'h07C3.
- R3: Bytes leave in the order they were accepted. `rd_data` shows the popped byte from the cycle after the accepted read strobe. Each push adds one to the count and each pop subtracts one. A push and a pop in the same cycle leave the count unchanged. A read strobe on an empty queue changes neither the count nor `rd_data`.
- R4: The RTS level select maps 0→15, 1→1, 2→4, 3→6, 4→8, 5→10, 6→12, 7→14. `rts_out` is high exactly when the count is strictly greater than the selected level. It follows the count in the same cycle the count changes.
- R5: The data-ready level select maps 0→1, 1→4, 2→8, 3→14. `rx_full_flag` is high exactly when the count is greater than or equal to the selected level. It clears once the count falls below that level.
- R6: A push while the count is 16 is dropped. The stored bytes and the count stay unchanged, and `overrun` goes high. `overrun` stays high until reset or until the flush bit is set.
- R7: While the flush bit is 1, the count is held at 0, pushes and pops are discarded, and `overrun` is cleared. Once the bit is written back to 0, normal queuing resumes from empty.
- R8: `loopback_en` always equals control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 8 | Most recently popped byte |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| cfg_rdata | output | 16 | Control word read value |
| fill_count | output | 5 | Bytes held, 0 to 16 |
| rx_full_flag | output | 1 | Data-ready status flag |
| rts_out | output | 1 | Flow-control request pin |
| overrun | output | 1 | Sticky dropped-push indication |
| loopback_en | output | 1 | Loopback enable for the serial datapath |

## Verification
The main threshold logic is driven from a table of cases. Each case selects a pair of level encodings and fills the queue to exactly the level, or to one byte past it. Landing on the level is the point where the inclusive data-ready comparison and the strict RTS comparison must disagree, so each of the twelve encodings is exercised on both sides of its boundary. Separate streams check ordering with mixed and simultaneous push and pop, a full queue receiving one extra byte (which shows whether the byte was dropped or overwrote stored data), and pushes issued during a flush.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CFG_W   = 16;
  localparam int RTS_LO  = 8;
  localparam int RTS_W   = 3;
  localparam int RDF_LO  = 6;
  localparam int RDF_W   = 2;
  localparam int FLUSH_B = 1;
  localparam int LOOP_B  = 0;

  typedef struct packed {
    logic [RTS_W-1:0] rts_sel;
    logic [RDF_W-1:0] rdf_sel;
    logic             flush;
    logic             loop;
  } rxq_cfg_t;

  // RTS trigger: code 0 is the top level, code 1 the bottom, others double
  function automatic int unsigned rts_level(input logic [RTS_W-1:0] sel);
    if (sel == '0)
      return 15;
    else if (sel == RTS_W'(1))
      return 1;
    else
      return 2 * int'(sel);
  endfunction

  function automatic int unsigned rdf_level(input logic [RDF_W-1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ctrl_reg.sv
module rxq_ctrl_reg
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output rxq_cfg_t         cfg,
  output logic [CFG_W-1:0] rdata
);

  rxq_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.rts_sel <= wdata[RTS_LO +: RTS_W];
      cfg_q.rdf_sel <= wdata[RDF_LO +: RDF_W];
      cfg_q.flush   <= wdata[FLUSH_B];
      cfg_q.loop    <= wdata[LOOP_B];
    end
  end

  // bits outside the defined fields are not stored
  logic unused_wbits;
  assign unused_wbits = ^{wdata[CFG_W-1:RTS_LO+RTS_W], wdata[RDF_LO-1:FLUSH_B+1]};

  always_comb begin
    rdata                    = '0;
    rdata[RTS_LO +: RTS_W]   = cfg_q.rts_sel;
    rdata[RDF_LO +: RDF_W]   = cfg_q.rdf_sel;
    rdata[FLUSH_B]           = cfg_q.flush;
    rdata[LOOP_B]            = cfg_q.loop;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push_req,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count,
  output logic              overrun
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] rdata_q;
  logic              ovr_q;
  logic              full, empty, push_ok, pop_ok, drop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push_req && !flush && !full;
  assign pop_ok  = pop_req  && !flush && !empty;
  assign drop    = push_req && !flush && full;

  // storage array: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
    if (pop_ok)  rdata_q   <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      ovr_q <= 1'b0;
    else if (drop)
      ovr_q <= 1'b1;
  end

  assign rdata   = rdata_q;
  assign count   = cnt;
  assign overrun = ovr_q;

endmodule

// File: rtl/rxq_level_cmp.sv
module rxq_level_cmp #(
  parameter int CW     = 5,
  parameter bit STRICT = 1'b0
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] level,
  output logic          hit
);

  generate
    if (STRICT) begin : g_gt
      assign hit = (count > level);
    end else begin : g_ge
      assign hit = (count >= level);
    end
  endgenerate

endmodule

// File: rtl/rxq_fifo_top.sv
module rxq_fifo_top
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [CW-1:0]     fill_count,
  output logic              rx_full_flag,
  output logic              rts_out,
  output logic              overrun,
  output logic              loopback_en
);

  rxq_cfg_t      cfg;
  logic [CW-1:0] count;
  logic [CW-1:0] rts_lvl, rdf_lvl;

  rxq_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (cfg.flush),
    .push_req (wr_en),
    .wdata    (wr_data),
    .pop_req  (rd_en),
    .rdata    (rd_data),
    .count    (count),
    .overrun  (overrun)
  );

  assign rts_lvl = CW'(rts_level(cfg.rts_sel));
  assign rdf_lvl = CW'(rdf_level(cfg.rdf_sel));

  rxq_level_cmp #(.CW(CW), .STRICT(1'b1)) u_rts_cmp (
    .count (count),
    .level (rts_lvl),
    .hit   (rts_out)
  );

  rxq_level_cmp #(.CW(CW), .STRICT(1'b0)) u_rdf_cmp (
    .count (count),
    .level (rdf_lvl),
    .hit   (rx_full_flag)
  );

  assign fill_count  = count;
  assign loopback_en = cfg.loop;

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic [15:0]   cfg_rdata,
  input logic [CW-1:0] fill_count,
  input logic          rx_full_flag,
  input logic          rts_out,
  input logic          overrun,
  input logic          loopback_en
);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[15:11] == 5'd0 && cfg_rdata[5:2] == 4'd0);

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CW'(DEPTH));

  // R3
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !rd_en && !cfg_rdata[1] && fill_count < CW'(DEPTH)
    |=> fill_count == $past(fill_count) + 1'b1);

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !wr_en && !cfg_rdata[1] && fill_count != '0
    |=> fill_count == $past(fill_count) - 1'b1);

  // R4
  rts_low_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count <= CW'(1) |-> !rts_out);

  // R4
  rts_top_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count == CW'(DEPTH) && cfg_rdata[10:8] == 3'd0 |-> rts_out);

  // R5
  flag_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count == '0 |-> !rx_full_flag);

  // R5
  flag_high_chk: assert property (@(posedge clk) disable iff (rst)
    fill_count >= CW'(14) |-> rx_full_flag);

  // R6
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !rd_en && !cfg_rdata[1] && fill_count == CW'(DEPTH)
    |=> overrun && fill_count == CW'(DEPTH));

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !cfg_rdata[1] |=> overrun);

  // R7
  flush_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[1] |=> fill_count == '0 && !overrun);

  // R8
  loop_pin_chk: assert property (@(posedge clk) disable iff (rst)
    loopback_en == cfg_rdata[0]);

endmodule

bind rxq_fifo_top rxq_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .cfg_rdata    (cfg_rdata),
  .fill_count   (fill_count),
  .rx_full_flag (rx_full_flag),
  .rts_out      (rts_out),
  .overrun      (overrun),
  .loopback_en  (loopback_en)
);

// File: tb/rxq_fifo_top_test.sv
`timescale 1ns/1ps
module rxq_fifo_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [4:0]  fill_count;
  logic        rx_full_flag, rts_out, overrun, loopback_en;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  rxq_fifo_top uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .fill_count(fill_count), .rx_full_flag(rx_full_flag),
    .rts_out(rts_out), .overrun(overrun), .loopback_en(loopback_en)
  );

  // {rts_sel[2:0], rdf_sel[1:0], fill[4:0], exp_rts, exp_flag}
  localparam logic [11:0] VEC [20] = '{
    {3'd0, 2'd0, 5'd0,  1'b0, 1'b0},
    {3'd0, 2'd0, 5'd1,  1'b0, 1'b1},
    {3'd0, 2'd3, 5'd13, 1'b0, 1'b0},
    {3'd0, 2'd3, 5'd14, 1'b0, 1'b1},
    {3'd0, 2'd3, 5'd15, 1'b0, 1'b1},
    {3'd0, 2'd3, 5'd16, 1'b1, 1'b1},
    {3'd1, 2'd1, 5'd1,  1'b0, 1'b0},
    {3'd1, 2'd1, 5'd2,  1'b1, 1'b0},
    {3'd2, 2'd1, 5'd4,  1'b0, 1'b1},
    {3'd2, 2'd1, 5'd5,  1'b1, 1'b1},
    {3'd3, 2'd2, 5'd6,  1'b0, 1'b0},
    {3'd3, 2'd2, 5'd7,  1'b1, 1'b0},
    {3'd4, 2'd2, 5'd8,  1'b0, 1'b1},
    {3'd4, 2'd2, 5'd9,  1'b1, 1'b1},
    {3'd5, 2'd2, 5'd10, 1'b0, 1'b1},
    {3'd5, 2'd2, 5'd11, 1'b1, 1'b1},
    {3'd6, 2'd3, 5'd12, 1'b0, 1'b0},
    {3'd6, 2'd3, 5'd13, 1'b1, 1'b0},
    {3'd7, 2'd3, 5'd14, 1'b0, 1'b1},
    {3'd7, 2'd3, 5'd15, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic flush_with(input logic [15:0] keep);
    cfg_write(keep | 16'h0002);
    cfg_write(keep);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(fill_count), 0);
    check("R1 cfg", 32'(cfg_rdata), 0);
    check("R1 pins", {28'd0, rts_out, rx_full_flag, overrun, loopback_en}, 0);

    // R4 R5 table walk
    for (int v = 0; v < 20; v++) begin
      logic [15:0] w;
      w = {5'd0, VEC[v][11:9], VEC[v][8:7], 6'd0};
      flush_with(w);
      for (int i = 0; i < int'(VEC[v][6:2]); i++) push(8'(i));
      check($sformatf("R2 cfg vec%0d", v), 32'(cfg_rdata), 32'(w));
      check($sformatf("R3 count vec%0d", v), 32'(fill_count), 32'(VEC[v][6:2]));
      check($sformatf("R4 rts vec%0d", v), 32'(rts_out), 32'(VEC[v][1]));
      check($sformatf("R5 flag vec%0d", v), 32'(rx_full_flag), 32'(VEC[v][0]));
    end

    // R5 flag clears when count drops below level (rdf 4)
    flush_with(16'h0040);
    for (int i = 0; i < 4; i++) push(8'(i));
    check("R5 at level", 32'(rx_full_flag), 1);
    pop();
    check("R5 below level", 32'(rx_full_flag), 0);

    // R3 ordering, simultaneous push/pop, empty pop
    flush_with(16'h0000);
    for (int i = 0; i < 5; i++) push(8'hA1 + 8'(i));
    for (int i = 0; i < 3; i++) begin
      pop();
      check("R3 order", 32'(rd_data), 32'(8'hA1 + 8'(i)));
    end
    check("R3 count after pops", 32'(fill_count), 2);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hB0; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R3 simul data", 32'(rd_data), 32'h A4);
    check("R3 simul count", 32'(fill_count), 2);
    pop(); check("R3 order A5", 32'(rd_data), 32'hA5);
    pop(); check("R3 order B0", 32'(rd_data), 32'hB0);
    pop();
    check("R3 empty pop count", 32'(fill_count), 0);
    check("R3 empty pop data", 32'(rd_data), 32'hB0);

    // R6 full and overrun
    flush_with(16'h0000);
    for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
    check("R6 full count", 32'(fill_count), 16);
    check("R6 no overrun yet", 32'(overrun), 0);
    push(8'hEE);
    check("R6 drop count", 32'(fill_count), 16);
    check("R6 overrun set", 32'(overrun), 1);
    for (int i = 0; i < 16; i++) begin
      pop();
      check("R6 data kept", 32'(rd_data), 32'(8'h10 + 8'(i)));
    end
    check("R6 overrun sticky", 32'(overrun), 1);

    // R7 flush
    push(8'h01); push(8'h02); push(8'h03);
    cfg_write(16'h0002);
    @(negedge clk);
    check("R7 flush count", 32'(fill_count), 0);
    check("R6 overrun cleared by flush", 32'(overrun), 0);
    push(8'h77);
    check("R7 push discarded", 32'(fill_count), 0);
    cfg_write(16'h0000);
    check("R7 still empty", 32'(fill_count), 0);
    push(8'h5A); pop();
    check("R7 resume data", 32'(rd_data), 32'h5A);

    // R2 R8 reserved bits and loopback
    cfg_write(16'hFFFF);
    check("R2 readback", 32'(cfg_rdata), 32'h07C3);
    check("R8 loop on", 32'(loopback_en), 1);
    cfg_write(16'h0000);
    check("R8 loop off", 32'(loopback_en), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule